// File: doc/BRIEF.md
# Display RAM Access Address Generator

This block keeps the data pointer for a byte-wide display memory organised as four banks of forty columns, a memory that is spread over a chain of cascaded driver chips. The pointer is a column address, a bank number and a device subaddress counter. For every data byte moved over the host link the block presents the memory location of that byte and, once the byte is done, steps the pointer in the order of the selected access mode. The mode can be a single bank, alternating pairs of banks, or a sweep over all four banks.

When the column passes its last value, the pointer returns to column 0 and to the starting bank, and the subaddress counter moves on to the next chip in the chain. The block compares that counter with its own hardware subaddress and only lets read and write requests reach the local memory when the two are equal. Software-level commands are decoded elsewhere. The decoded values arrive here as load strobes for the column, the bank, the mode and the subaddress.

Top module: `dram_ptr_unit`

## Requirements
- R1: After reset the pointer is column 0, bank 0, subaddress 0, and the mode is character (mode code 00). The flat address is 0 and `is_mine` is high.
- R2: In character mode (code 00), each `byte_done` adds one to the column and leaves the bank unchanged.
- R3: In half-graphic mode (code 01), the bank pair starts on an even bank: a loaded odd bank is reduced by one. Each `byte_done` on the even bank moves to the odd bank at the same column. Each `byte_done` on the odd bank returns to the even bank and adds one to the column.
- R4: In full-graphic mode (code 10), the starting bank is always 0. Each `byte_done` steps the bank through 0, 1, 2, 3 at the same column, and after bank 3 it returns to bank 0 with the column plus one.
- R5: When the column would pass 39, it becomes 0, the bank becomes the starting bank, and the subaddress counter increments.
- R6: The subaddress counter wraps from 15 to 0.
- R7: `is_mine` is high exactly when the subaddress counter equals `HW_SUB` (default 0). `wr_en` = `wr_req` AND `is_mine`, and `rd_en` = `rd_req` AND `is_mine`.
- R8: `ram_addr` equals bank × 40 + column.
- R9: A column load above 39 stores 0. Loading the bank or the mode sets the current bank to the starting bank that the new values give.
- R10: In a cycle where any load strobe is high, `byte_done` is ignored: only the loaded fields change.
- R11: The reserved mode code 11 steps exactly as character mode does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_x | input | 1 | Load column strobe |
| x_in | input | 6 | Column value to load |
| ld_bank | input | 1 | Load starting bank strobe |
| bank_in | input | 2 | Starting bank to load |
| ld_mode | input | 1 | Load access mode strobe |
| mode_in | input | 2 | Access mode: 00 char, 01 half, 10 full, 11 as char |
| ld_sub | input | 1 | Load subaddress counter strobe |
| sub_in | input | 4 | Subaddress value to load |
| byte_done | input | 1 | One data byte transferred; advance pointer |
| wr_req | input | 1 | Write request for the current byte |
| rd_req | input | 1 | Read request for the current byte |
| ram_bank | output | 2 | Current bank |
| ram_x | output | 6 | Current column |
| ram_addr | output | 8 | Flat memory address |
| sub_cnt | output | 4 | Subaddress counter |
| is_mine | output | 1 | Current byte belongs to this device |
| wr_en | output | 1 | Gated write enable |
| rd_en | output | 1 | Gated read enable |

## Verification
A load and a byte advance can arrive in the same cycle. The most telling case is a column load, or a subaddress load, together with `byte_done`. The bench raises both strobes on one edge and judges the result by the visible pointer: it must hold the loaded value and show no step, and the column must not have moved. A second coincidence is the column wrap together with the subaddress counter at 15. The bench provokes it by loading subaddress 15 and column 39 and then advancing once. It expects column 0, the starting bank, subaddress 0 and `is_mine` high, all after the same edge.

// File: rtl/dram_ptr_pkg.sv
package dram_ptr_pkg;
  typedef enum logic [1:0] {
    AM_CHAR = 2'b00,
    AM_HALF = 2'b01,
    AM_FULL = 2'b10,
    AM_RSVD = 2'b11
  } acc_mode_e;
endpackage

// File: rtl/dram_col_ctr.sv
module dram_col_ctr #(
  parameter int COLS = 40,
  localparam int X_W = $clog2(COLS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld,
  input  logic [X_W-1:0] val,
  input  logic           adv,
  output logic [X_W-1:0] x,
  output logic           wrap
);
  localparam logic [X_W-1:0] X_LAST = X_W'(COLS - 1);

  function automatic logic [X_W-1:0] clamp_x(input logic [X_W-1:0] v);
    return (v > X_LAST) ? '0 : v;
  endfunction

  assign wrap = adv && (x == X_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      x <= '0;
    else if (ld)     x <= clamp_x(val);
    else if (wrap)   x <= '0;
    else if (adv)    x <= x + 1'b1;
  end

  assert_x_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    x <= X_LAST);
  assert_x_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ld) |=> (x == '0));
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_ptr_pkg::*;
#(
  parameter int BANKS = 4,
  localparam int B_W = $clog2(BANKS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_bank,
  input  logic [B_W-1:0] bank_in,
  input  logic           ld_mode,
  input  logic [1:0]     mode_in,
  input  logic           step,
  output logic [B_W-1:0] bank,
  output acc_mode_e      mode,
  output logic           col_step
);
  localparam logic [B_W-1:0] B_LAST = B_W'(BANKS - 1);

  logic [B_W-1:0] start_q;
  logic [B_W-1:0] start_d;
  acc_mode_e      mode_d;

  function automatic logic [B_W-1:0] eff_start(input acc_mode_e m, input logic [B_W-1:0] s);
    case (m)
      AM_HALF: return {s[B_W-1:1], 1'b0};
      AM_FULL: return '0;
      default: return s;
    endcase
  endfunction

  function automatic logic group_last(input acc_mode_e m, input logic [B_W-1:0] b);
    case (m)
      AM_HALF: return b[0];
      AM_FULL: return b == B_LAST;
      default: return 1'b1;
    endcase
  endfunction

  assign start_d  = ld_bank ? bank_in : start_q;
  assign mode_d   = ld_mode ? acc_mode_e'(mode_in) : mode;
  assign col_step = step && group_last(mode, bank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      mode    <= AM_CHAR;
      bank    <= '0;
    end else if (ld_bank || ld_mode) begin
      start_q <= start_d;
      mode    <= mode_d;
      bank    <= eff_start(mode_d, start_d);
    end else if (col_step) begin
      bank    <= eff_start(mode, start_q);
    end else if (step) begin
      bank    <= bank + 1'b1;
    end
  end

  assert_half_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_HALF && step && !bank[0] && !ld_bank && !ld_mode) |=> (bank == $past(bank) + 1'b1));
  assert_full_sweep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_FULL && col_step && !ld_bank && !ld_mode) |=> (bank == '0));
endmodule

// File: rtl/dram_sub_ctr.sv
module dram_sub_ctr #(
  parameter int SUB_W = 4,
  parameter logic [SUB_W-1:0] HW_SUB = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [SUB_W-1:0] val,
  input  logic             inc,
  output logic [SUB_W-1:0] cnt,
  output logic             match
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (ld)   cnt <= val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign match = (cnt == HW_SUB);

  assert_sub_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && cnt == '1) |=> (cnt == '0));
  assert_sub_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(cnt));
endmodule

// File: rtl/dram_ptr_unit.sv
module dram_ptr_unit
  import dram_ptr_pkg::*;
#(
  parameter int COLS  = 40,
  parameter int BANKS = 4,
  parameter int SUB_W = 4,
  parameter logic [SUB_W-1:0] HW_SUB = '0,
  localparam int X_W = $clog2(COLS),
  localparam int B_W = $clog2(BANKS),
  localparam int A_W = $clog2(COLS * BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_x,
  input  logic [X_W-1:0]   x_in,
  input  logic             ld_bank,
  input  logic [B_W-1:0]   bank_in,
  input  logic             ld_mode,
  input  logic [1:0]       mode_in,
  input  logic             ld_sub,
  input  logic [SUB_W-1:0] sub_in,
  input  logic             byte_done,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic [B_W-1:0]   ram_bank,
  output logic [X_W-1:0]   ram_x,
  output logic [A_W-1:0]   ram_addr,
  output logic [SUB_W-1:0] sub_cnt,
  output logic             is_mine,
  output logic             wr_en,
  output logic             rd_en
);
  localparam logic [X_W-1:0] X_LAST = X_W'(COLS - 1);

  logic      any_ld;
  logic      step;
  logic      col_step;
  logic      col_wrap;
  acc_mode_e cur_mode;

  function automatic logic [A_W-1:0] flat_addr(input logic [B_W-1:0] b, input logic [X_W-1:0] x);
    return A_W'(b) * A_W'(COLS) + A_W'(x);
  endfunction

  assign any_ld = ld_x | ld_bank | ld_mode | ld_sub;
  assign step   = byte_done & ~any_ld;

  dram_bank_seq #(.BANKS(BANKS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .ld_bank(ld_bank), .bank_in(bank_in),
    .ld_mode(ld_mode), .mode_in(mode_in),
    .step(step), .bank(ram_bank), .mode(cur_mode), .col_step(col_step)
  );

  dram_col_ctr #(.COLS(COLS)) u_col (
    .clk(clk), .rst_n(rst_n),
    .ld(ld_x), .val(x_in), .adv(col_step),
    .x(ram_x), .wrap(col_wrap)
  );

  dram_sub_ctr #(.SUB_W(SUB_W), .HW_SUB(HW_SUB)) u_sub (
    .clk(clk), .rst_n(rst_n),
    .ld(ld_sub), .val(sub_in), .inc(col_wrap),
    .cnt(sub_cnt), .match(is_mine)
  );

  assign ram_addr = flat_addr(ram_bank, ram_x);
  assign wr_en    = wr_req & is_mine;
  assign rd_en    = rd_req & is_mine;

  assert_char_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cur_mode == AM_CHAR && ram_x != X_LAST) |=>
      (ram_x == $past(ram_x) + 1'b1) && (ram_bank == $past(ram_bank)));
  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> (sub_cnt == HW_SUB));
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ld_sub && !ld_x) |=> $stable(ram_x));
endmodule

// File: tb/tb_dram_ptr_unit.sv
module tb_dram_ptr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_x = 0, ld_bank = 0, ld_mode = 0, ld_sub = 0;
  logic [5:0] x_in = '0;
  logic [1:0] bank_in = '0, mode_in = '0;
  logic [3:0] sub_in = '0;
  logic       byte_done = 0, wr_req = 0, rd_req = 0;
  logic [1:0] ram_bank;
  logic [5:0] ram_x;
  logic [7:0] ram_addr;
  logic [3:0] sub_cnt;
  logic       is_mine, wr_en, rd_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_ptr_unit dut (
    .clk(clk), .rst_n(rst_n),
    .ld_x(ld_x), .x_in(x_in), .ld_bank(ld_bank), .bank_in(bank_in),
    .ld_mode(ld_mode), .mode_in(mode_in), .ld_sub(ld_sub), .sub_in(sub_in),
    .byte_done(byte_done), .wr_req(wr_req), .rd_req(rd_req),
    .ram_bank(ram_bank), .ram_x(ram_x), .ram_addr(ram_addr), .sub_cnt(sub_cnt),
    .is_mine(is_mine), .wr_en(wr_en), .rd_en(rd_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_ptr(input string tag, input int b, input int x, input int s);
    chk({tag, " bank"}, int'(ram_bank), b);
    chk({tag, " col"}, int'(ram_x), x);
    chk({tag, " sub"}, int'(sub_cnt), s);
    chk({tag, " addr R8"}, int'(ram_addr), b * 40 + x);
  endtask

  task automatic edge_go();
    @(posedge clk);
    #2;
    ld_x = 0; ld_bank = 0; ld_mode = 0; ld_sub = 0; byte_done = 0;
  endtask

  task automatic setup(input int m, input int b, input int x, input int s);
    ld_mode = 1; mode_in = 2'(m);
    ld_bank = 1; bank_in = 2'(b);
    ld_x = 1; x_in = 6'(x);
    ld_sub = 1; sub_in = 4'(s);
    edge_go();
  endtask

  task automatic adv();
    byte_done = 1;
    edge_go();
  endtask

  task automatic t_reset();
    chk_ptr("R1 reset", 0, 0, 0);
    chk("R1 is_mine", int'(is_mine), 1);
    adv();
    chk_ptr("R1 char after reset", 0, 1, 0);
  endtask

  task automatic t_char();
    setup(0, 2, 5, 0);
    chk_ptr("R2 load", 2, 5, 0);
    adv(); chk_ptr("R2 step1", 2, 6, 0);
    adv(); chk_ptr("R2 step2", 2, 7, 0);
    adv(); chk_ptr("R2 step3", 2, 8, 0);
  endtask

  task automatic t_half();
    setup(1, 3, 10, 0);
    chk_ptr("R3 odd forced even", 2, 10, 0);
    adv(); chk_ptr("R3 b1", 3, 10, 0);
    adv(); chk_ptr("R3 b2", 2, 11, 0);
    adv(); chk_ptr("R3 b3", 3, 11, 0);
    adv(); chk_ptr("R3 b4", 2, 12, 0);
  endtask

  task automatic t_full();
    setup(2, 1, 20, 0);
    chk_ptr("R4 start 0", 0, 20, 0);
    adv(); chk_ptr("R4 b1", 1, 20, 0);
    adv(); chk_ptr("R4 b2", 2, 20, 0);
    adv(); chk_ptr("R4 b3", 3, 20, 0);
    adv(); chk_ptr("R4 b4", 0, 21, 0);
    adv(); adv();
    ld_mode = 1; mode_in = 2'b10;
    edge_go();
    chk_ptr("R9 mode reload restarts bank", 0, 21, 0);
  endtask

  task automatic t_wrap();
    setup(0, 1, 38, 0);
    adv(); chk_ptr("R5 char at 39", 1, 39, 0);
    adv(); chk_ptr("R5 char wrap", 1, 0, 1);
    chk("R7 not mine after wrap", int'(is_mine), 0);
    setup(1, 2, 39, 2);
    adv(); chk_ptr("R5 half at 39 odd", 3, 39, 2);
    adv(); chk_ptr("R5 half wrap", 2, 0, 3);
    setup(2, 0, 39, 4);
    adv(); adv(); adv();
    chk_ptr("R5 full at 39 bank3", 3, 39, 4);
    adv(); chk_ptr("R5 full wrap", 0, 0, 5);
  endtask

  task automatic t_subwrap();
    setup(0, 0, 39, 15);
    chk("R7 sub15 not mine", int'(is_mine), 0);
    adv();
    chk_ptr("R6 sub wraps", 0, 0, 0);
    chk("R6 is_mine after wrap", int'(is_mine), 1);
  endtask

  task automatic t_gate();
    setup(0, 0, 0, 0);
    wr_req = 1; rd_req = 1; #1;
    chk("R7 wr_en mine", int'(wr_en), 1);
    chk("R7 rd_en mine", int'(rd_en), 1);
    ld_sub = 1; sub_in = 4'd5;
    edge_go();
    chk("R7 is_mine other", int'(is_mine), 0);
    chk("R7 wr_en other", int'(wr_en), 0);
    chk("R7 rd_en other", int'(rd_en), 0);
    wr_req = 0; rd_req = 0; #1;
    ld_sub = 1; sub_in = 4'd0;
    edge_go();
    chk("R7 wr_en idle", int'(wr_en), 0);
  endtask

  task automatic t_loads();
    setup(0, 1, 45, 0);
    chk_ptr("R9 col over 39 stores 0", 1, 0, 0);
    ld_x = 1; x_in = 6'd39;
    edge_go();
    chk_ptr("R9 col 39", 1, 39, 0);
  endtask

  task automatic t_collide();
    setup(0, 0, 4, 0);
    byte_done = 1; ld_x = 1; x_in = 6'd9;
    edge_go();
    chk_ptr("R10 col load wins", 0, 9, 0);
    byte_done = 1; ld_sub = 1; sub_in = 4'd7;
    edge_go();
    chk_ptr("R10 sub load, no step", 0, 9, 7);
    setup(2, 0, 3, 0);
    byte_done = 1; ld_bank = 1; bank_in = 2'd2;
    edge_go();
    chk_ptr("R10 bank load, no step", 0, 3, 0);
  endtask

  task automatic t_mode3();
    setup(3, 3, 0, 0);
    chk_ptr("R11 load", 3, 0, 0);
    adv(); chk_ptr("R11 step1", 3, 1, 0);
    adv(); chk_ptr("R11 step2", 3, 2, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #5;
    t_reset();
    t_char();
    t_half();
    t_full();
    t_wrap();
    t_subwrap();
    t_gate();
    t_loads();
    t_collide();
    t_mode3();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule